// File: doc/BRIEF.md
# Stuck Speed-Change Recovery Watchdog

This block watches a serial link while it moves to a higher line rate. It catches the case where the link stops in the receiver-lock stage of recovery while the receiver never reports valid data. It frees the link by pulsing two override bits in the PHY receiver for a timed window. The override word is held in a local register. Its value goes straight to the PHY, so no PHY bus access is involved.

The block is sampled on every clock. If the link is up and not training, it is reported good in that same cycle. If the link is down, a recovery pulse starts. If the link is up but still training, the block waits a grace period and then looks at the training-state code and the receiver-valid flag. The grace and pulse lengths are parameters in clock cycles. They are set short by default for simulation. In real use both must stay well below the 24 ms training timeout (a grace of 1 to 2 ms and a pulse of 2 to 3 ms).

Top module: `spdchg_rescue`

## Requirements
- R1: While reset is held, `ovrd_o` equals OVRD_RST (default 16'h0A41, with bits 5 and 3 clear) and `stuck_evt_o` is 0.
- R2: In the idle state, a clock edge that samples `link_up_i` = 0 starts a recovery pulse. The override bits are set and `stuck_evt_o` goes high after that same edge.
- R3: When `link_up_i` = 1 and `in_train_i` = 0 and no pulse is running, `link_good_o` is 1 in the same cycle, with no clock edge in between.
- R4: An idle edge that samples link up and training starts a grace window. The inputs are judged only at the edge GRACE_CYC clock edges later. No recovery starts before that edge.
- R5: At the end of the grace window, recovery starts if the low six bits of `train_state_i` equal 6'h0D and `rx_valid_i` = 0.
- R6: At the end of the grace window, any other code, or `rx_valid_i` = 1, starts no recovery. The block goes back to idle.
- R7: A recovery sets `ovrd_o` bit 5 (receiver data enable) and bit 3 (receiver PLL enable) together. It holds both for exactly PULSE_CYC cycles and then clears both.
- R8: Every `ovrd_o` bit other than 5 and 3 keeps its reset value at all times.
- R9: `stuck_evt_o` is high for one cycle per recovery. No new recovery starts while a pulse is running. A link that stays down retriggers recovery one edge after the pulse ends.
- R10: If training ends during the grace window, the window is dropped. Good is reported at once, and no recovery follows.
- R11: `link_good_o` is 0 while a recovery pulse is running, whatever the link inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | PHY reports link up |
| in_train_i | input | 1 | Link training still in progress |
| train_state_i | input | 6 | Training-state machine code |
| rx_valid_i | input | 1 | PHY receiver valid flag |
| ovrd_o | output | 16 | Receiver override register value |
| stuck_evt_o | output | 1 | One-cycle flag at recovery start |
| link_good_o | output | 1 | Link up and training finished |

## Verification
The hardest case to reach is the stuck decision itself. It is made on one edge only, a fixed number of cycles after training is first seen, and it depends on the exact code and the receiver-valid level on that edge. The bench sweeps all 64 codes with both receiver-valid levels. For each case it holds the inputs steady through the whole grace window, records the cycle in which the event flag rises, and measures how long the override bits stay high. A link held down is used to show that recovery retriggers only after the pulse ends. Training is also dropped in the middle of a grace window to show that the window is abandoned.

// File: rtl/rescue_pkg.sv
package rescue_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRACE = 2'd1,
    ST_PULSE = 2'd2
  } rescue_st_e;
endpackage

// File: rtl/rescue_timer.sv
module rescue_timer #(
  parameter int GRACE_CYC = 20,
  parameter int PULSE_CYC = 30,
  parameter int CNT_W     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_grace_i,
  input  logic ld_pulse_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (ld_grace_i)      cnt_q <= CNT_W'(GRACE_CYC - 1);
    else if (ld_pulse_i)      cnt_q <= CNT_W'(PULSE_CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_single_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_grace_i && ld_pulse_i));
endmodule

// File: rtl/rescue_fsm.sv
module rescue_fsm
  import rescue_pkg::*;
#(
  parameter logic [5:0] STUCK_CODE = 6'h0D
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_up_i,
  input  logic       in_train_i,
  input  logic [5:0] train_state_i,
  input  logic       rx_valid_i,
  input  logic       tmr_done_i,
  output logic       ld_grace_o,
  output logic       ld_pulse_o,
  output logic       pulse_end_o,
  output rescue_st_e st_o
);
  rescue_st_e st_q, st_d;
  logic       stuck;

  assign stuck = (train_state_i == STUCK_CODE) && !rx_valid_i;

  always_comb begin
    st_d        = st_q;
    ld_grace_o  = 1'b0;
    ld_pulse_o  = 1'b0;
    pulse_end_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!link_up_i) begin
          st_d = ST_PULSE; ld_pulse_o = 1'b1;
        end else if (in_train_i) begin
          st_d = ST_GRACE; ld_grace_o = 1'b1;
        end
      end
      ST_GRACE: begin
        if (link_up_i && !in_train_i) st_d = ST_IDLE;  // training done early
        else if (tmr_done_i) begin
          if (stuck) begin
            st_d = ST_PULSE; ld_pulse_o = 1'b1;
          end else st_d = ST_IDLE;
        end
      end
      ST_PULSE: begin
        if (tmr_done_i) begin
          st_d = ST_IDLE; pulse_end_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  // grace exits to pulse only once the timer has run out
  p_grace_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GRACE && ld_pulse_o) |-> tmr_done_i);
  p_no_retrigger_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULSE) |-> !ld_pulse_o);
endmodule

// File: rtl/rescue_ovrd.sv
module rescue_ovrd #(
  parameter int              OVRD_W   = 16,
  parameter logic [OVRD_W-1:0] OVRD_RST = 16'h0A41,
  parameter int              DEN_BIT  = 5,
  parameter int              PEN_BIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [OVRD_W-1:0] ovrd_o,
  output logic              evt_o
);
  localparam logic [OVRD_W-1:0] MASK = (OVRD_W'(1) << DEN_BIT) | (OVRD_W'(1) << PEN_BIT);

  logic [OVRD_W-1:0] ovrd_q;
  logic              evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovrd_q <= OVRD_RST;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= set_i;
      if (set_i)      ovrd_q <= ovrd_q | MASK;
      else if (clr_i) ovrd_q <= ovrd_q & ~MASK;
    end
  end

  assign ovrd_o = ovrd_q;
  assign evt_o  = evt_q;

  p_bits_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovrd_q[DEN_BIT] == ovrd_q[PEN_BIT]);
  p_others_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ovrd_q & ~MASK));
endmodule

// File: rtl/spdchg_rescue.sv
module spdchg_rescue
  import rescue_pkg::*;
#(
  parameter int                GRACE_CYC  = 20,
  parameter int                PULSE_CYC  = 30,
  parameter int                OVRD_W     = 16,
  parameter logic [OVRD_W-1:0] OVRD_RST   = 16'h0A41,
  parameter logic [5:0]        STUCK_CODE = 6'h0D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic              in_train_i,
  input  logic [5:0]        train_state_i,
  input  logic              rx_valid_i,
  output logic [OVRD_W-1:0] ovrd_o,
  output logic              stuck_evt_o,
  output logic              link_good_o
);
  localparam int DEN_BIT = 5;
  localparam int PEN_BIT = 3;
  localparam int MAX_CYC = (GRACE_CYC > PULSE_CYC) ? GRACE_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic       ld_grace, ld_pulse, pulse_end, tmr_done;
  rescue_st_e st;

  rescue_timer #(
    .GRACE_CYC(GRACE_CYC), .PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)
  ) i_timer (
    .clk_i, .rst_ni, .ld_grace_i(ld_grace), .ld_pulse_i(ld_pulse), .done_o(tmr_done)
  );

  rescue_fsm #(.STUCK_CODE(STUCK_CODE)) i_fsm (
    .clk_i, .rst_ni, .link_up_i, .in_train_i, .train_state_i, .rx_valid_i,
    .tmr_done_i(tmr_done), .ld_grace_o(ld_grace), .ld_pulse_o(ld_pulse),
    .pulse_end_o(pulse_end), .st_o(st)
  );

  rescue_ovrd #(
    .OVRD_W(OVRD_W), .OVRD_RST(OVRD_RST), .DEN_BIT(DEN_BIT), .PEN_BIT(PEN_BIT)
  ) i_ovrd (
    .clk_i, .rst_ni, .set_i(ld_pulse), .clr_i(pulse_end),
    .ovrd_o, .evt_o(stuck_evt_o)
  );

  assign link_good_o = link_up_i && !in_train_i && (st != ST_PULSE);

  // pulse-length observer for assertions
  logic [CNT_W-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hi_cnt_q <= '0;
    else if (ovrd_o[DEN_BIT]) hi_cnt_q <= hi_cnt_q + 1'b1;
    else                      hi_cnt_q <= '0;
  end

  p_evt_sets_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_evt_o |-> (ovrd_o[DEN_BIT] && !$past(ovrd_o[DEN_BIT])));
  p_evt_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_evt_o |=> !stuck_evt_o);
  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovrd_o[DEN_BIT]) |-> (hi_cnt_q == CNT_W'(PULSE_CYC)));
  p_good_no_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_good_o |-> !ovrd_o[DEN_BIT]);
endmodule

// File: tb/test_spdchg_rescue.sv
`timescale 1ns/1ps
module test_spdchg_rescue;
  localparam int          G    = 20;
  localparam int          P    = 30;
  localparam logic [15:0] RSTV = 16'h0A41;
  localparam logic [15:0] MASK = 16'h0028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b1, in_train = 1'b0, rx_valid = 1'b1;
  logic [5:0] tstate = '0;
  logic [15:0] ovrd;
  logic evt, good;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  spdchg_rescue #(.GRACE_CYC(G), .PULSE_CYC(P), .OVRD_RST(RSTV)) i_spdchg_rescue (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up), .in_train_i(in_train),
    .train_state_i(tstate), .rx_valid_i(rx_valid),
    .ovrd_o(ovrd), .stuck_evt_o(evt), .link_good_o(good)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();  // link good, let any pulse finish
    @(negedge clk);
    link_up = 1'b1; in_train = 1'b0; rx_valid = 1'b1; tstate = '0;
    repeat (P + 3) @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ovrd == RSTV, "R1 reset ovrd", ovrd, RSTV);
    chk(evt == 1'b0, "R1 reset evt", evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(good == 1'b1, "R3 good at once", good, 1);

    // sweep stuck decision: all codes, both rx_valid levels
    for (int c = 0; c < 64; c++) begin
      for (int rv = 0; rv < 2; rv++) begin
        bit exp_stuck;
        int evt_cnt, evt_at, hi_cnt;
        bit others_ok;
        exp_stuck = (c == 6'h0D) && (rv == 0);
        settle();
        in_train = 1'b1; tstate = 6'(c); rx_valid = rv[0];
        evt_cnt = 0; evt_at = 0; hi_cnt = 0; others_ok = 1'b1;
        for (int i = 1; i <= G + P + 5; i++) begin
          @(posedge clk); #1;
          if (evt) begin evt_cnt++; evt_at = i; end
          if (ovrd[5]) hi_cnt++;
          if ((ovrd & ~MASK) != RSTV) others_ok = 1'b0;
          if (ovrd[5] && good) others_ok = 1'b0;
        end
        if (exp_stuck) begin
          chk(evt_cnt == 1, "R5 stuck detected", evt_cnt, 1);
          chk(evt_at == G + 1, "R4 eval after grace", evt_at, G + 1);
          chk(hi_cnt == P, "R7 pulse length", hi_cnt, P);
          chk(ovrd[3] == 1'b0 && ovrd[5] == 1'b0, "R7 bits cleared", ovrd, 0);
        end else begin
          chk(evt_cnt == 0, "R6 no recovery", evt_cnt, 0);
          chk(hi_cnt == 0, "R6 no override", hi_cnt, 0);
        end
        chk(others_ok, "R8 other bits kept / R11", ovrd, RSTV);
      end
    end

    // link down held: single event per pulse, retrigger after end
    begin
      int evt_cnt, good_hi;
      settle();
      link_up = 1'b0;
      evt_cnt = 0; good_hi = 0;
      for (int i = 1; i <= P + 2; i++) begin
        @(posedge clk); #1;
        if (i == 1) chk(evt == 1'b1 && ovrd[5] && ovrd[3], "R2 link down starts pulse", ovrd, RSTV | MASK);
        if (evt && i <= P + 1) evt_cnt++;
        if (i == P + 2) chk(evt == 1'b1, "R9 retrigger after pulse", evt, 1);
        if (good) good_hi++;
      end
      chk(evt_cnt == 1, "R9 one event per pulse", evt_cnt, 1);
      chk(good_hi == 0, "R11 no good when down", good_hi, 0);
    end

    // good inputs during pulse: link_good held low
    begin
      settle();
      link_up = 1'b0;
      @(posedge clk); #1;
      @(negedge clk);
      link_up = 1'b1; in_train = 1'b0;
      #1;
      chk(good == 1'b0, "R11 good masked during pulse", good, 0);
      repeat (P + 1) @(negedge clk);
      #1;
      chk(good == 1'b1, "R3 good after pulse", good, 1);
    end

    // training ends mid-grace: window dropped
    begin
      int evt_cnt;
      settle();
      in_train = 1'b1; tstate = 6'h0D; rx_valid = 1'b0;
      repeat (G / 2) @(negedge clk);
      in_train = 1'b0;
      #1;
      chk(good == 1'b1, "R10 good at once mid-grace", good, 1);
      evt_cnt = 0;
      for (int i = 0; i < G + 5; i++) begin
        @(posedge clk); #1;
        if (evt) evt_cnt++;
      end
      chk(evt_cnt == 0, "R10 no recovery after drop", evt_cnt, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule